// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block drives an open-drain single-wire bus that idles high through an external pullup. It accepts two commands on a simple command port. The initialization command drives the line low for a long reset pulse and then releases it. It then listens for a connected device to answer by pulling the line low, and reports whether one did. The byte-write command sends eight data bits as timed write slots. The width of the low pulse in each slot carries the bit value: a short pulse means 1 and a long pulse means 0.

All timing is counted in microseconds. A divider turns the system clock into a one-microsecond tick, and the divider is restarted whenever a command is accepted. Because of this, every low and released interval is an exact whole number of microsecond periods of clock cycles. The line input passes through a two-flop synchronizer before it is used. Commands that arrive while the block is busy are dropped.

Top module: `swire_master`

## Requirements
- R1: On an accepted initialization command (`cmd_op` = 0), `line_drive_low` goes high in the cycle after acceptance and stays high for exactly RST_LOW_US × CLK_PER_US cycles (default 480 µs).
- R2: After the reset pulse the line is released for exactly LISTEN_US × CLK_PER_US cycles (default 480 µs). `busy` stays high from the cycle after acceptance until `done` is raised at the end of this listen window.
- R3: `presence` is loaded with the inverse of the synchronized line, sampled PRES_SAMPLE_US (default 70 µs) after release. It is cleared when an initialization command is accepted and otherwise holds its value, including across byte writes. A device answering 15 to 60 µs after release and holding the line low for at least 60 µs is therefore reported as present. A device that answers only after the sample point, or releases the line before it, is reported as absent.
- R4: A byte write (`cmd_op` = 1) sends each slot as a low pulse first. A 1 bit is sent with a low time of exactly W1_LOW_US × CLK_PER_US cycles (default 6 µs, within 15 µs).
- R5: A 0 bit holds the line low for exactly SLOT_US × CLK_PER_US cycles (default 60 µs).
- R6: After each low pulse the line is released for (SLOT_US − low time + RECOV_US) µs. Every slot therefore lasts SLOT_US µs and is followed by RECOV_US µs (default 2 µs) of released recovery.
- R7: The eight bits of `cmd_data` are sent least-significant bit first, exactly eight slots per command.
- R8: `done` is a one-cycle pulse raised when the final interval ends: the listen window, or the recovery time of the eighth slot. `busy` is low in that same cycle.
- R9: A `cmd_valid` that arrives while `busy` is high is ignored. It does not change the pulse train in progress or `presence`.
- R10: After reset, `line_drive_low`, `busy`, `done` and `presence` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_op | input | 1 | 0 = initialization with presence detect, 1 = write byte |
| cmd_data | input | 8 | Byte to send, LSB first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Device answered the last initialization |
| line_drive_low | output | 1 | Output enable that pulls the bus low |
| line_in | input | 1 | Raw level of the bus |

## Verification
The command is accepted at the first clock edge after `cmd_valid` is presented, and `line_drive_low` changes at that same edge. Every later boundary falls an exact multiple of CLK_PER_US cycles after the previous one. The bench counts, at falling clock edges, how many consecutive samples the drive stays high or low, and compares each count with the microsecond figure times the divider. `done` is expected at the sample directly after the last released interval, with `busy` already low, and is checked to be gone one sample later. The presence sample lags the line by the two synchronizer flops. For that reason the device responses in the bench start or end several cycles away from the 70 µs point, so that their expected outcome does not depend on that two-cycle lag.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_LISTEN,
    ST_BIT_LOW,
    ST_BIT_HIGH
  } swire_state_t;

  localparam logic OP_INIT  = 1'b0;
  localparam logic OP_WRITE = 1'b1;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/swire_us_tick.sv
module swire_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_chk
      a_r1_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/swire_sync2.sv
module swire_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b1;
      q    <= 1'b1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int CLK_PER_US     = 100,
  parameter int RST_LOW_US     = 480,
  parameter int LISTEN_US      = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int SLOT_US        = 60,
  parameter int W1_LOW_US      = 6,
  parameter int RECOV_US       = 2,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic              line_drive_low,
  input  logic              line_in
);
  localparam int MAX_US = max2(max2(RST_LOW_US, LISTEN_US),
                               SLOT_US + RECOV_US);
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  localparam logic [US_W-1:0] LEN_RST    = US_W'(RST_LOW_US - 1);
  localparam logic [US_W-1:0] LEN_LISTEN = US_W'(LISTEN_US - 1);
  localparam logic [US_W-1:0] LEN_SMP    = US_W'(PRES_SAMPLE_US - 1);
  localparam logic [US_W-1:0] LEN_W1_LO  = US_W'(W1_LOW_US - 1);
  localparam logic [US_W-1:0] LEN_W0_LO  = US_W'(SLOT_US - 1);
  localparam logic [US_W-1:0] LEN_W1_HI  = US_W'(SLOT_US - W1_LOW_US + RECOV_US - 1);
  localparam logic [US_W-1:0] LEN_W0_HI  = US_W'(RECOV_US - 1);
  localparam logic [US_W-1:0] W1_LIMIT   = US_W'(W1_LOW_US);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_W - 1);

  swire_state_t      state;
  logic [US_W-1:0]   us_cnt;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  bit_idx;
  logic              tick;
  logic              line_s;
  logic              accept;
  logic              phase_end;
  logic [US_W-1:0]   phase_last;

  assign accept = cmd_valid && !busy;

  swire_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .restart(accept), .tick(tick)
  );

  swire_sync2 u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  always_comb begin
    case (state)
      ST_RST_LOW:    phase_last = LEN_RST;
      ST_RST_LISTEN: phase_last = LEN_LISTEN;
      ST_BIT_LOW:    phase_last = shreg[0] ? LEN_W1_LO : LEN_W0_LO;
      ST_BIT_HIGH:   phase_last = shreg[0] ? LEN_W1_HI : LEN_W0_HI;
      default:       phase_last = '0;
    endcase
  end

  assign phase_end = tick && (us_cnt == phase_last) && (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      us_cnt         <= '0;
      shreg          <= '0;
      bit_idx        <= '0;
      busy           <= 1'b0;
      done           <= 1'b0;
      presence       <= 1'b0;
      line_drive_low <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            busy           <= 1'b1;
            us_cnt         <= '0;
            line_drive_low <= 1'b1;
            if (cmd_op == OP_INIT) begin
              state    <= ST_RST_LOW;
              presence <= 1'b0;
            end else begin
              state   <= ST_BIT_LOW;
              shreg   <= cmd_data;
              bit_idx <= '0;
            end
          end
        end
        ST_RST_LOW: begin
          if (phase_end) begin
            us_cnt         <= '0;
            line_drive_low <= 1'b0;
            state          <= ST_RST_LISTEN;
          end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
          end
        end
        ST_RST_LISTEN: begin
          if (tick && us_cnt == LEN_SMP) presence <= !line_s;
          if (phase_end) begin
            us_cnt <= '0;
            state  <= ST_IDLE;
            busy   <= 1'b0;
            done   <= 1'b1;
          end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
          end
        end
        ST_BIT_LOW: begin
          if (phase_end) begin
            us_cnt         <= '0;
            line_drive_low <= 1'b0;
            state          <= ST_BIT_HIGH;
          end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
          end
        end
        ST_BIT_HIGH: begin
          if (phase_end) begin
            us_cnt <= '0;
            if (bit_idx == LAST_IDX) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              bit_idx        <= bit_idx + 1'b1;
              shreg          <= shreg >> 1;
              line_drive_low <= 1'b1;
              state          <= ST_BIT_LOW;
            end
          end else if (tick) begin
            us_cnt <= us_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a 1 bit never keeps the line low past its short pulse
  a_r4_w1_short: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BIT_LOW && shreg[0]) |-> (us_cnt < W1_LIMIT));

  // R8: completion is a single-cycle pulse with busy already cleared
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: a strobe while busy does not restart the sequence
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && !phase_end) |=> (state == $past(state)));

  // R3: presence only moves in the listen window or on a new initialization
  a_r3_presence_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RST_LISTEN && !accept) |=> $stable(presence));

  // R1: the line is driven only while busy
  a_r1_drive_busy: assert property (@(posedge clk) disable iff (rst)
    line_drive_low |-> busy);
endmodule

// File: tb/swire_master_bench.sv
module swire_master_bench;
  localparam int K   = 4;
  localparam int RL  = 480;
  localparam int LI  = 480;
  localparam int SL  = 60;
  localparam int W1  = 6;
  localparam int RC  = 2;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, cmd_op;
  logic [7:0] cmd_data;
  logic busy, done, presence, line_drive_low;
  logic dev_low;
  logic line_in;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign line_in = !(line_drive_low || dev_low);

  swire_master #(.CLK_PER_US(K)) u_swire_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .presence(presence),
    .line_drive_low(line_drive_low), .line_in(line_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic op, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
  endtask

  task automatic run_reset(input int d_us, input int w_us, input bit exp_pres,
                           input bit inject);
    int n;
    int t;
    start_cmd(1'b0, 8'h00);
    n = 0;
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (!line_drive_low) break;
      if (n == 0) chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      if (inject && n == 5) begin cmd_valid = 1'b1; cmd_op = 1'b1; cmd_data = 8'h00; end
      n++;
    end
    chk(n == RL * K, "R1 reset low cycles", n, RL * K);
    t = 0;
    forever begin
      dev_low = (t >= d_us * K) && (t < (d_us + w_us) * K);
      @(negedge clk);
      t++;
      if (done || line_drive_low) break;
    end
    dev_low = 1'b0;
    chk(t == LI * K, "R2 listen cycles", t, LI * K);
    chk(done == 1'b1 && busy == 1'b0, "R8 done with busy low after init", {busy, done}, 1);
    chk(presence == exp_pres, "R3 presence", presence, exp_pres);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  task automatic run_write(input logic [7:0] v, input bit inject);
    int lo;
    int hi;
    logic [7:0] seen;
    bit pres0;
    pres0 = presence;
    seen = 8'h00;
    start_cmd(1'b1, v);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(line_drive_low == 1'b1, "R4 slot starts low", line_drive_low, 1);
    for (int b = 0; b < 8; b++) begin
      lo = 1;
      forever begin
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!line_drive_low) break;
        if (inject && b == 3 && lo == 2) begin
          cmd_valid = 1'b1; cmd_op = 1'b0; cmd_data = 8'hFF;
        end
        lo++;
      end
      hi = 1;
      forever begin
        @(negedge clk);
        if (line_drive_low || done) break;
        hi++;
      end
      if (v[b]) begin
        chk(lo == W1 * K, "R4 write-1 low cycles", lo, W1 * K);
        chk(hi == (SL - W1 + RC) * K, "R6 write-1 released cycles", hi, (SL - W1 + RC) * K);
      end else begin
        chk(lo == SL * K, "R5 write-0 low cycles", lo, SL * K);
        chk(hi == RC * K, "R6 write-0 recovery cycles", hi, RC * K);
      end
      seen[b] = (lo < SL * K);
      if (b < 7) chk(line_drive_low == 1'b1 && !done, "R7 next slot follows", line_drive_low, 1);
    end
    chk(seen == v, "R7 LSB-first byte", seen, v);
    chk(done == 1'b1 && busy == 1'b0, "R8 done after eighth slot", {busy, done}, 1);
    @(negedge clk);
    chk(done == 1'b0 && line_drive_low == 1'b0, "R8 done single cycle, line idle",
        {line_drive_low, done}, 0);
    chk(presence == pres0, "R9 presence untouched by write", presence, pres0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_data = 8'h00; dev_low = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({line_drive_low, busy, done, presence} == 4'b0000, "R10 reset outputs",
        {line_drive_low, busy, done, presence}, 0);

    // R3 device response variants
    run_reset(15, 60, 1'b1, 1'b0);
    run_reset(60, 60, 1'b1, 1'b0);
    run_reset(0, 0, 1'b0, 1'b0);
    run_reset(30, 240, 1'b1, 1'b1);  // R9: write strobe during reset low
    run_reset(72, 60, 1'b0, 1'b0);
    run_reset(15, 50, 1'b0, 1'b0);
    run_reset(20, 100, 1'b1, 1'b0);

    run_write(8'h00, 1'b0);
    run_write(8'hFF, 1'b0);
    run_write(8'hA5, 1'b1);          // R9: init strobe during slot 3
    run_write(8'h5A, 1'b0);
    for (int i = 0; i < 8; i++) run_write(8'(1 << i), 1'b0);
    for (int i = 0; i < 8; i++) run_write(~8'(1 << i), 1'b0);

    run_reset(0, 0, 1'b0, 1'b0);
    run_write(8'h3C, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule